// File: doc/BRIEF.md
# Message Bus Target Receiver

This block is the receive half of a target on a 32-bit synchronous message-passing bus. An initiator frames each message by holding an active-low envelope line low for the whole transfer. The target uses the falling edge of the envelope to begin a message. It reads the first word the initiator marks valid as a header. A bitmap in that header says whether the message is meant for this target.

Words are taken only in cycles where the initiator-ready line is high. Wait cycles leave the receiver untouched. Payload words from an addressed message pass through a one-word output register that a downstream consumer empties with an acknowledge. A frame data message may end with a receive-status word, tagged by an active-low end-of-frame line. That word goes to a separate status register and does not enter the output register.

If a payload word arrives while the output register still holds an unacknowledged word, the target pulses an active-low abort and discards the rest of the message. When the envelope rises, an addressed message is closed with a one-cycle done pulse. Two flags travel with the pulse: one says the message was aborted, the other says a status word was seen.

Top module: `msg_target_rx`

## Requirements
- R1: While reset is held, and until the first message, `abort_no` is 1 and `word_valid_o`, `hdr_hit_o`, `done_o` and `stat_o` are 0.
- R2: After the envelope falls, the header is the first word sampled with `irdy_i` high. The message is addressed to the target when bit `tgt_id_i` of the header's low `NUM_TGT` bits is 1. `hdr_hit_o` then reads 1 from the cycle after the header until the message closes.
- R3: Bus words sampled with `irdy_i` low are never taken as a header, payload or status word.
- R4: In an addressed message, a payload word (`irdy_i` 1, `eof_ni` 1) appears on `word_o` with `word_valid_o` 1 in the following cycle. The word is held unchanged until a cycle in which `word_ack_i` is 1.
- R5: A word sampled with `irdy_i` 1 and `eof_ni` 0 in an addressed message loads `stat_o` in the following cycle. It leaves `word_o` and `word_valid_o` untouched and sets the end-of-frame flag of the coming done pulse.
- R6: When the header does not address the target, the remaining words of that message change no output, and no done pulse is produced.
- R7: When a payload word arrives while `word_valid_o` is 1 and `word_ack_i` is 0, `abort_no` is 0 for exactly the next cycle. The old word stays in place, and every later word of the message is ignored.
- R8: For an addressed message, `done_o` is 1 for exactly one cycle, the cycle after the envelope is sampled high again. `done_abort_o` and `done_eof_o` report the abort and status-word flags, and `hdr_hit_o` returns to 0 in that same cycle.
- R9: A payload word that arrives in a cycle where `word_ack_i` empties a full output register is loaded, and no abort results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_id_i | input | ID_W | Bit position of this target in the header bitmap |
| bus_data_i | input | DATA_W | Bus data word |
| env_ni | input | 1 | Message envelope, active low |
| irdy_i | input | 1 | Initiator ready, high when the bus word is valid |
| eof_ni | input | 1 | End-of-frame tag on the status word, active low |
| word_ack_i | input | 1 | Consumer takes the held output word |
| abort_no | output | 1 | Target abort pulse, active low |
| word_o | output | DATA_W | Received payload word |
| word_valid_o | output | 1 | `word_o` holds an unconsumed word |
| hdr_hit_o | output | 1 | Current message is addressed to this target |
| stat_o | output | DATA_W | Last receive-status word |
| done_o | output | 1 | One-cycle message-complete pulse |
| done_abort_o | output | 1 | Completed message was aborted (valid with `done_o`) |
| done_eof_o | output | 1 | Completed message carried a status word (valid with `done_o`) |

## Verification
The bench uses the defaults: DATA_W of 32 and NUM_TGT of 8, which gives a 3-bit target ID. It selects target bits 5 and then 0, so the header decode is tested at an inner position and at the edge of the bitmap. Random header values mean the unused upper header bits never affect the match decision. Random acknowledge and wait-state rates regularly fill the one-word output register. This brings aborts, same-cycle acknowledge with load, and headers delayed by wait states within reach, alongside status-tagged and untagged endings.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } mrx_state_e;
endpackage

// File: rtl/mrx_env_edge.sv
module mrx_env_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic env_ni,
  output logic start_o,
  output logic stop_o
);
  logic env_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) env_q <= 1'b1;
    else         env_q <= env_ni;
  end

  assign start_o = env_q & ~env_ni;
  assign stop_o  = ~env_q & env_ni;
endmodule

// File: rtl/mrx_hdr_match.sv
module mrx_hdr_match #(
  parameter int NUM_TGT = 8,
  localparam int ID_W = $clog2(NUM_TGT)
) (
  input  logic [NUM_TGT-1:0] map_i,
  input  logic [ID_W-1:0]    tgt_id_i,
  output logic               hit_o
);
  assign hit_o = map_i[tgt_id_i];
endmodule

// File: rtl/mrx_out_reg.sv
module mrx_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      word_o  <= data_i;
      valid_o <= 1'b1;
    end else if (ack_i) begin
      valid_o <= 1'b0;
    end
  end

  assign busy_o = valid_o & ~ack_i;

  // R4
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(word_o));
endmodule

// File: rtl/msg_target_rx.sv
module msg_target_rx
  import mrx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = 8,
  localparam int ID_W = $clog2(NUM_TGT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   tgt_id_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              env_ni,
  input  logic              irdy_i,
  input  logic              eof_ni,
  input  logic              word_ack_i,
  output logic              abort_no,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              hdr_hit_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              done_o,
  output logic              done_abort_o,
  output logic              done_eof_o
);
  mrx_state_e state_q;
  logic start, stop, hit, busy, load;
  logic hit_q, ab_q, eof_q;

  mrx_env_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .env_ni (env_ni),
    .start_o(start),
    .stop_o (stop)
  );

  mrx_hdr_match #(.NUM_TGT(NUM_TGT)) u_match (
    .map_i   (bus_data_i[NUM_TGT-1:0]),
    .tgt_id_i(tgt_id_i),
    .hit_o   (hit)
  );

  // payload word: addressed, valid, not status, register free or emptying
  assign load = (state_q == ST_DATA) && !stop && irdy_i && eof_ni && !busy;

  mrx_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (bus_data_i),
    .ack_i  (word_ack_i),
    .word_o (word_o),
    .valid_o(word_valid_o),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      hit_q        <= 1'b0;
      ab_q         <= 1'b0;
      eof_q        <= 1'b0;
      stat_o       <= '0;
      abort_no     <= 1'b1;
      done_o       <= 1'b0;
      done_abort_o <= 1'b0;
      done_eof_o   <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      abort_no <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ab_q  <= 1'b0;
            eof_q <= 1'b0;
            if (irdy_i) begin
              hit_q   <= hit;
              state_q <= hit ? ST_DATA : ST_SKIP;
            end else begin
              state_q <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (stop) begin
            state_q <= ST_IDLE;
          end else if (irdy_i) begin
            hit_q   <= hit;
            state_q <= hit ? ST_DATA : ST_SKIP;
          end
        end
        ST_DATA: begin
          if (stop) begin
            done_o       <= 1'b1;
            done_abort_o <= ab_q;
            done_eof_o   <= eof_q;
            hit_q        <= 1'b0;
            state_q      <= ST_IDLE;
          end else if (irdy_i) begin
            if (!eof_ni) begin
              stat_o <= bus_data_i;
              eof_q  <= 1'b1;
            end else if (busy) begin
              abort_no <= 1'b0;
              ab_q     <= 1'b1;
              state_q  <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (stop) begin
            if (hit_q) begin
              done_o       <= 1'b1;
              done_abort_o <= ab_q;
              done_eof_o   <= eof_q;
            end
            hit_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hdr_hit_o = hit_q;

  // R7
  abort_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_no |=> abort_no);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_hit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hdr_hit_o);

  // R3
  load_needs_irdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> $past(irdy_i));

  // R7
  abort_keeps_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_no |-> word_valid_o && $stable(word_o));
endmodule

// File: tb/msg_target_rx_bench.sv
module msg_target_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tgt_id = 3'd5;
  logic [31:0] bus = '0;
  logic        env_n = 1'b1, irdy = 1'b0, eof_n = 1'b1, ack = 1'b0;
  logic        abort_n, wvalid, hit, done, dab, deof;
  logic [31:0] word, stat;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bench model
  int          m_st = 0;
  bit          m_prev = 1, m_valid = 0, m_hit = 0, m_ab = 0, m_eof = 0;
  logic [31:0] m_word = '0, m_stat = '0;
  bit          e_done, e_abort_n, e_dab, e_deof;

  always #4 clk = ~clk;

  msg_target_rx u_msg_target_rx (
    .clk_i(clk), .rst_ni(rst_n), .tgt_id_i(tgt_id), .bus_data_i(bus),
    .env_ni(env_n), .irdy_i(irdy), .eof_ni(eof_n), .word_ack_i(ack),
    .abort_no(abort_n), .word_o(word), .word_valid_o(wvalid),
    .hdr_hit_o(hit), .stat_o(stat), .done_o(done),
    .done_abort_o(dab), .done_eof_o(deof)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input string ctx, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s (%s) actual=%h expected=%h", req, what, ctx, act, exp);
    end
  endtask

  function automatic bit addr_hit(input logic [31:0] h);
    return h[tgt_id];
  endfunction

  task automatic step(input bit e, input bit r, input bit f, input logic [31:0] d,
                      input bit a, input string ctx);
    bit start, stop, pre;
    start = m_prev && !e;
    stop  = !m_prev && e;
    pre   = m_valid;
    e_done = 0; e_abort_n = 1;
    if (m_valid && a) m_valid = 0;
    case (m_st)
      0: if (start) begin
        m_ab = 0; m_eof = 0;
        if (r) begin m_hit = addr_hit(d); m_st = m_hit ? 2 : 3; end
        else m_st = 1;
      end
      1: if (stop) m_st = 0;
         else if (r) begin m_hit = addr_hit(d); m_st = m_hit ? 2 : 3; end
      2: if (stop) begin
           e_done = 1; e_dab = m_ab; e_deof = m_eof; m_hit = 0; m_st = 0;
         end else if (r) begin
           if (!f) begin m_stat = d; m_eof = 1; end
           else if (pre && !a) begin e_abort_n = 0; m_ab = 1; m_st = 3; end
           else begin m_valid = 1; m_word = d; end
         end
      default: if (stop) begin
           if (m_hit) begin e_done = 1; e_dab = m_ab; e_deof = m_eof; end
           m_hit = 0; m_st = 0;
         end
    endcase
    m_prev = e;
    env_n = e; irdy = r; eof_n = f; bus = d; ack = a;
    @(posedge clk);
    @(negedge clk);
    chk(wvalid == m_valid, "R4", "word_valid", ctx, 32'(wvalid), 32'(m_valid));
    if (m_valid) chk(word == m_word, "R4", "word", ctx, word, m_word);
    chk(abort_n == e_abort_n, "R7", "abort_n", ctx, 32'(abort_n), 32'(e_abort_n));
    chk(hit == m_hit, "R2", "hdr_hit", ctx, 32'(hit), 32'(m_hit));
    chk(done == e_done, "R8", "done", ctx, 32'(done), 32'(e_done));
    if (e_done) begin
      chk(dab == e_dab, "R8", "done_abort", ctx, 32'(dab), 32'(e_dab));
      chk(deof == e_deof, "R5", "done_eof", ctx, 32'(deof), 32'(e_deof));
    end
    chk(stat == m_stat, "R5", "stat", ctx, stat, m_stat);
  endtask

  function automatic logic [31:0] mk_hdr(input bit want);
    logic [31:0] h = $urandom;
    h[tgt_id] = want;
    return h;
  endfunction

  task automatic rand_msg(input string ctx);
    int n = 1 + $urandom_range(0, 7);
    bit tag = $urandom_range(0, 1);
    bit want = ($urandom_range(0, 9) < 6);
    while ($urandom_range(0, 3) == 0) step(0, 0, 1, $urandom, $urandom_range(0, 1), ctx);
    step(0, 1, 1, mk_hdr(want), $urandom_range(0, 1), ctx);
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(0, 3) == 0) step(0, 0, $urandom_range(0, 1), $urandom, $urandom_range(0, 1), ctx);
      step(0, 1, !(tag && i == n - 1), $urandom, $urandom_range(0, 1), ctx);
    end
    for (int g = 0; g <= $urandom_range(0, 2); g++) step(1, 0, 1, $urandom, $urandom_range(0, 1), ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(abort_n == 1'b1, "R1", "abort_n in reset", "reset", 32'(abort_n), 32'd1);
    chk(wvalid == 1'b0, "R1", "word_valid in reset", "reset", 32'(wvalid), 32'd0);
    chk(hit == 1'b0 && done == 1'b0, "R1", "hit/done in reset", "reset", 32'({hit, done}), 32'd0);
    chk(stat == '0, "R1", "stat in reset", "reset", stat, 32'd0);
    rst_n = 1'b1;
    step(1, 1, 1, 32'hFFFF_FFFF, 0, "R1 idle");

    // R2 R3: wait states before header, payload words, status word
    step(0, 0, 1, 32'h0000_0000, 0, "R3 wait before hdr");
    step(0, 1, 1, 32'hABCD_0020, 0, "R2 header hit");
    step(0, 1, 1, 32'h1111_1111, 0, "R4 word");
    step(0, 0, 1, 32'h9999_9999, 1, "R3 wait no latch");
    step(0, 1, 1, 32'h2222_2222, 1, "R4 word2");
    step(0, 1, 0, 32'h5757_0001, 1, "R5 status");
    step(1, 0, 1, 32'h0, 0, "R8 end eof");
    step(1, 0, 1, 32'h0, 1, "R8 after");

    // R6: header misses the target, payload ignored
    step(0, 1, 1, 32'hFFFF_FFDF, 0, "R6 header miss");
    step(0, 1, 1, 32'h3333_3333, 0, "R6 ignored");
    step(0, 1, 0, 32'h4444_4444, 0, "R6 ignored status");
    step(1, 0, 1, 32'h0, 0, "R6 no done");

    // R7: abort on unconsumed word
    step(0, 1, 1, 32'h0000_0020, 0, "R7 hdr");
    step(0, 1, 1, 32'hAAAA_0001, 0, "R7 word1");
    step(0, 1, 1, 32'hAAAA_0002, 0, "R7 overrun");
    step(0, 1, 1, 32'hAAAA_0003, 1, "R7 discarded");
    step(0, 1, 0, 32'hAAAA_0004, 0, "R7 discarded status");
    step(1, 0, 1, 32'h0, 0, "R7 done abort");

    // R9: ack and load in the same cycle
    step(0, 1, 1, 32'h0000_0020, 0, "R9 hdr");
    step(0, 1, 1, 32'hBBBB_0001, 0, "R9 word1");
    step(0, 1, 1, 32'hBBBB_0002, 1, "R9 ack+load");
    step(0, 1, 1, 32'hBBBB_0003, 1, "R9 ack+load2");
    step(1, 0, 1, 32'h0, 1, "R9 end");

    for (int k = 0; k < 300; k++) rand_msg("random id5");
    tgt_id = 3'd0;
    step(1, 0, 1, 32'h0, 1, "id change");
    for (int k = 0; k < 300; k++) rand_msg("random id0");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule